// File: doc/BRIEF.md
# Leveled interrupt request and acknowledge controller

This block collects interrupt requests from a fixed population of sources, organised as several priority levels of 32 sources each. Each source owns one request bit and one enable bit. A source is addressed by the flat index `level*32 + bit`. The block raises a single pending output whenever any source has both its request and its enable bit set.

A processor-side acknowledge strobe picks one enabled request and clears it. Level 0 is scanned first, and within a level the lowest bit is taken. In the same clock the block reads a programmable device-number table at the winner's flat index. On the following edge it presents that number with a valid flag.

A per-source 2-bit control field enables, disables or disarms a source and reports the resulting armed state. A disarm drops both the enable bit and any pending request. A registered 2-bit set/clear/toggle helper is also provided for neighbouring device logic.

Top module: `irq_lvl_ctrl`

## Requirements
- R1: A synchronous active-high reset clears every request and enable bit and drives `pend_o`, `ack_valid_o`, `ack_dev_o`, `ctl_armed_o` and `fld_new_o` to zero.
- R2: After each clock edge, `pend_o` is 1 exactly when at least one source has both its stored request bit and its stored enable bit set. A request with its enable bit clear does not raise `pend_o`.
- R3: On acknowledge, the winner is the enabled request with the lowest flat index `level*32 + bit`. Lower levels therefore win over higher ones, and lower bits win within a level.
- R4: An acknowledge in cycle N clears the winner's request bit at edge N. After that edge, `ack_valid_o` is 1 for exactly one cycle and `ack_dev_o` equals the table entry at the winner's flat index. Otherwise `ack_valid_o` is 0 and `ack_dev_o` holds its value.
- R5: An acknowledge with no enabled request pending still gives `ack_valid_o` = 1, with `ack_dev_o` = 0.
- R6: A 1 on `req_set_i[i]` ORs into request bit i at the next edge. If that set coincides with an acknowledge clear or a disarm clear of the same bit, the bit ends set.
- R7: With `ctl_valid_i` high, `ctl_code_i` acts on source `ctl_src_i` and updates `ctl_armed_o` at the next edge. The codes are: 0 keeps the enable bit and copies `ctl_armed_prev_i`; 1 sets the enable bit and reports 1; 2 clears the enable bit and reports 1; 3 disarms. With `ctl_valid_i` low, `ctl_armed_o` holds.
- R8: A disarm (code 3) clears both the enable bit and the request bit of the source and reports `ctl_armed_o` = 0.
- R9: `fld_new_o` is registered from `fld_code_i` and `fld_old_i`: 0 gives the old value, 1 gives 1, 2 gives 0, 3 gives the complement of the old value.
- R10: A table write (`tbl_we_i`) stores `tbl_data_i` at `tbl_addr_i`. The write is dropped in any cycle where `ack_i` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_set_i | input | NUM_LEVELS*SRC_PER_LEVEL | Per-source request set pulses |
| ctl_valid_i | input | 1 | Control command strobe |
| ctl_src_i | input | SRC_W | Flat index of the source being controlled |
| ctl_code_i | input | 2 | Control code (0 keep, 1 enable, 2 disable, 3 disarm) |
| ctl_armed_prev_i | input | 1 | Armed state returned for code 0 |
| ctl_armed_o | output | 1 | Registered armed report |
| ack_i | input | 1 | Acknowledge strobe |
| ack_valid_o | output | 1 | One-cycle flag after an acknowledge |
| ack_dev_o | output | DEV_W | Device number of the acknowledged source, 0 if none |
| pend_o | output | 1 | Any enabled request pending |
| tbl_we_i | input | 1 | Device table write enable |
| tbl_addr_i | input | SRC_W | Device table write address (flat source index) |
| tbl_data_i | input | DEV_W | Device table write data |
| fld_code_i | input | 2 | Set/clear/toggle helper code |
| fld_old_i | input | 1 | Helper old value |
| fld_new_o | output | 1 | Registered helper result |

## Verification
The hardest case to reach from the ports is an acknowledge where the winner's request bit is cleared and set again in the same cycle. That case needs the set pulse timed onto the very bit that will win, on the very cycle of the strobe.

The stimulus reaches it in two steps. First, other requests are drained so the winning source is known. Then `req_set_i` for that source is driven alongside `ack_i`. A table write on an acknowledge cycle is handled the same way: the entry is then read back by later acknowledges of that source.

A long random phase then mixes sets, control codes, acknowledges and writes. A behavioural model checks every cycle of it.

// File: rtl/irq_lvl_pkg.sv
package irq_lvl_pkg;

  typedef enum logic [1:0] {
    CTL_KEEP    = 2'd0,
    CTL_ENABLE  = 2'd1,
    CTL_DISABLE = 2'd2,
    CTL_DISARM  = 2'd3
  } ctl_code_e;

  typedef enum logic [1:0] {
    FLD_HOLD   = 2'd0,
    FLD_SET    = 2'd1,
    FLD_CLEAR  = 2'd2,
    FLD_INVERT = 2'd3
  } fld_code_e;

  // Two-bit field helper: hold, force one, force zero, invert.
  function automatic logic fld_apply(input logic [1:0] code, input logic old_v);
    logic r;
    case (fld_code_e'(code))
      FLD_SET:    r = 1'b1;
      FLD_CLEAR:  r = 1'b0;
      FLD_INVERT: r = ~old_v;
      default:    r = old_v;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/irq_lvl_prio.sv
// Lowest-index-first priority encoder.
module irq_lvl_prio #(
  parameter int W  = 32,
  parameter int IW = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]  vec,
  output logic          hit,
  output logic [IW-1:0] idx
);

  always_comb begin
    hit = |vec;
    idx = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec[i]) idx = IW'(i);
    end
  end

endmodule

// File: rtl/irq_lvl_ctl.sv
// Decodes the per-source control code into enable/request effects.
module irq_lvl_ctl
  import irq_lvl_pkg::*;
(
  input  logic       valid,
  input  logic [1:0] code,
  input  logic       armed_prev,
  output logic       en_set,
  output logic       en_clr,
  output logic       req_clr,
  output logic       armed_val
);

  always_comb begin
    en_set    = 1'b0;
    en_clr    = 1'b0;
    req_clr   = 1'b0;
    armed_val = armed_prev;
    if (valid) begin
      case (ctl_code_e'(code))
        CTL_ENABLE: begin
          en_set    = 1'b1;
          armed_val = 1'b1;
        end
        CTL_DISABLE: begin
          en_clr    = 1'b1;
          armed_val = 1'b1;
        end
        CTL_DISARM: begin
          en_clr    = 1'b1;
          req_clr   = 1'b1;
          armed_val = 1'b0;
        end
        default: armed_val = armed_prev;
      endcase
    end
  end

endmodule

// File: rtl/irq_lvl_table.sv
// Simple dual-port device-number table, synchronous read, no reset on storage.
module irq_lvl_table #(
  parameter int DEPTH = 128,
  parameter int DW    = 8,
  parameter int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end

endmodule

// File: rtl/irq_lvl_ctrl.sv
module irq_lvl_ctrl
  import irq_lvl_pkg::*;
#(
  parameter int NUM_LEVELS    = 4,
  parameter int SRC_PER_LEVEL = 32,
  parameter int DEV_W         = 8,
  localparam int NSRC  = NUM_LEVELS * SRC_PER_LEVEL,
  localparam int SRC_W = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NSRC-1:0]   req_set_i,
  input  logic              ctl_valid_i,
  input  logic [SRC_W-1:0]  ctl_src_i,
  input  logic [1:0]        ctl_code_i,
  input  logic              ctl_armed_prev_i,
  output logic              ctl_armed_o,
  input  logic              ack_i,
  output logic              ack_valid_o,
  output logic [DEV_W-1:0]  ack_dev_o,
  output logic              pend_o,
  input  logic              tbl_we_i,
  input  logic [SRC_W-1:0]  tbl_addr_i,
  input  logic [DEV_W-1:0]  tbl_data_i,
  input  logic [1:0]        fld_code_i,
  input  logic              fld_old_i,
  output logic              fld_new_o
);

  localparam int LVL_W = (NUM_LEVELS > 1) ? $clog2(NUM_LEVELS) : 1;
  localparam int BIT_W = (SRC_PER_LEVEL > 1) ? $clog2(SRC_PER_LEVEL) : 1;

  logic [NSRC-1:0]  req_q, en_q, req_nxt, en_nxt, pend_vec, ack_clr;
  logic             ack_valid_q, hit_q, pend_q, armed_q, fld_q;
  logic [DEV_W-1:0] tbl_q;

  assign pend_vec = req_q & en_q;

  // ---------------- winner search ----------------
  logic [NUM_LEVELS-1:0] lvl_hit;
  logic [BIT_W-1:0]      lvl_bit [NUM_LEVELS];
  logic                  win_hit;
  logic [LVL_W-1:0]      win_lvl;
  logic [BIT_W-1:0]      win_bit;
  logic [SRC_W-1:0]      win_idx;

  for (genvar l = 0; l < NUM_LEVELS; l++) begin : g_lvl
    irq_lvl_prio #(.W(SRC_PER_LEVEL), .IW(BIT_W)) u_bit_enc (
      .vec (pend_vec[l*SRC_PER_LEVEL +: SRC_PER_LEVEL]),
      .hit (lvl_hit[l]),
      .idx (lvl_bit[l])
    );
  end

  irq_lvl_prio #(.W(NUM_LEVELS), .IW(LVL_W)) u_lvl_enc (
    .vec (lvl_hit),
    .hit (win_hit),
    .idx (win_lvl)
  );

  always_comb begin
    win_bit = '0;
    for (int l = 0; l < NUM_LEVELS; l++) begin
      if (win_lvl == LVL_W'(l)) win_bit = lvl_bit[l];
    end
    win_idx = SRC_W'(win_lvl) * SRC_W'(SRC_PER_LEVEL) + SRC_W'(win_bit);
  end

  // ---------------- control decode ----------------
  logic en_set, en_clr, req_clr, armed_val;

  irq_lvl_ctl u_ctl (
    .valid      (ctl_valid_i),
    .code       (ctl_code_i),
    .armed_prev (ctl_armed_prev_i),
    .en_set     (en_set),
    .en_clr     (en_clr),
    .req_clr    (req_clr),
    .armed_val  (armed_val)
  );

  // ---------------- per-source next state ----------------
  for (genvar i = 0; i < NSRC; i++) begin : g_src
    logic sel;
    assign sel        = (ctl_src_i == SRC_W'(i));
    assign ack_clr[i] = ack_i && win_hit && (win_idx == SRC_W'(i));
    assign req_nxt[i] = (req_q[i] & ~ack_clr[i] & ~(sel & req_clr)) | req_set_i[i];
    assign en_nxt[i]  = (sel & en_set) ? 1'b1 :
                        (sel & en_clr) ? 1'b0 : en_q[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q       <= '0;
      en_q        <= '0;
      pend_q      <= 1'b0;
      ack_valid_q <= 1'b0;
      hit_q       <= 1'b0;
      armed_q     <= 1'b0;
      fld_q       <= 1'b0;
    end else begin
      req_q       <= req_nxt;
      en_q        <= en_nxt;
      pend_q      <= |(req_nxt & en_nxt);
      ack_valid_q <= ack_i;
      if (ack_i) hit_q <= win_hit;
      if (ctl_valid_i) armed_q <= armed_val;
      fld_q       <= fld_apply(fld_code_i, fld_old_i);
    end
  end

  // ---------------- device table ----------------
  irq_lvl_table #(.DEPTH(NSRC), .DW(DEV_W), .AW(SRC_W)) u_tbl (
    .clk   (clk),
    .we    (tbl_we_i & ~ack_i),
    .waddr (tbl_addr_i),
    .wdata (tbl_data_i),
    .re    (ack_i),
    .raddr (win_idx),
    .rdata (tbl_q)
  );

  assign ack_dev_o   = hit_q ? tbl_q : '0;
  assign ack_valid_o = ack_valid_q;
  assign pend_o      = pend_q;
  assign ctl_armed_o = armed_q;
  assign fld_new_o   = fld_q;

  // ---------------- assertions ----------------
  logic [NSRC-1:0] low_mask;
  assign low_mask = (NSRC'(1) << win_idx) - NSRC'(1);

  a_r3_lowest_wins: assert property (@(posedge clk) disable iff (rst)
    win_hit |-> (pend_vec[win_idx] && ((pend_vec & low_mask) == '0)));

  a_r4_ack_clears: assert property (@(posedge clk) disable iff (rst)
    (ack_i && win_hit && !req_set_i[win_idx]) |=> !req_q[$past(win_idx)]);

  a_r4_ack_flag: assert property (@(posedge clk) disable iff (rst)
    ack_i |=> ack_valid_o);

  a_r5_empty_zero: assert property (@(posedge clk) disable iff (rst)
    (ack_i && !win_hit) |=> (ack_dev_o == '0));

  a_r6_set_wins: assert property (@(posedge clk) disable iff (rst)
    (ack_i && win_hit && req_set_i[win_idx]) |=> req_q[$past(win_idx)]);

  a_r7_keep_copies: assert property (@(posedge clk) disable iff (rst)
    (ctl_valid_i && ctl_code_i == CTL_KEEP) |=> (ctl_armed_o == $past(ctl_armed_prev_i)));

  a_r8_disarm_drops: assert property (@(posedge clk) disable iff (rst)
    (ctl_valid_i && ctl_code_i == CTL_DISARM && !req_set_i[ctl_src_i])
      |=> (!req_q[$past(ctl_src_i)] && !en_q[$past(ctl_src_i)] && !ctl_armed_o));

endmodule

// File: tb/irq_lvl_ctrl_tb.sv
module irq_lvl_ctrl_tb_top;

  localparam int NUM_LEVELS = 4;
  localparam int SPL        = 32;
  localparam int DEV_W      = 8;
  localparam int NSRC       = NUM_LEVELS * SPL;
  localparam int SRC_W      = $clog2(NSRC);

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [NSRC-1:0]   req_set_i = '0;
  logic              ctl_valid_i = 1'b0;
  logic [SRC_W-1:0]  ctl_src_i = '0;
  logic [1:0]        ctl_code_i = '0;
  logic              ctl_armed_prev_i = 1'b0;
  logic              ctl_armed_o;
  logic              ack_i = 1'b0;
  logic              ack_valid_o;
  logic [DEV_W-1:0]  ack_dev_o;
  logic              pend_o;
  logic              tbl_we_i = 1'b0;
  logic [SRC_W-1:0]  tbl_addr_i = '0;
  logic [DEV_W-1:0]  tbl_data_i = '0;
  logic [1:0]        fld_code_i = '0;
  logic              fld_old_i = 1'b0;
  logic              fld_new_o;

  always #4 clk = ~clk;  // 125 MHz

  irq_lvl_ctrl #(.NUM_LEVELS(NUM_LEVELS), .SRC_PER_LEVEL(SPL), .DEV_W(DEV_W)) dut_i (
    .clk(clk), .rst(rst), .req_set_i(req_set_i),
    .ctl_valid_i(ctl_valid_i), .ctl_src_i(ctl_src_i), .ctl_code_i(ctl_code_i),
    .ctl_armed_prev_i(ctl_armed_prev_i), .ctl_armed_o(ctl_armed_o),
    .ack_i(ack_i), .ack_valid_o(ack_valid_o), .ack_dev_o(ack_dev_o), .pend_o(pend_o),
    .tbl_we_i(tbl_we_i), .tbl_addr_i(tbl_addr_i), .tbl_data_i(tbl_data_i),
    .fld_code_i(fld_code_i), .fld_old_i(fld_old_i), .fld_new_o(fld_new_o)
  );

  int n_chk  = 0;
  int n_fail = 0;
  int cyc    = 0;
  bit done   = 1'b0;
  bit cmp_on = 1'b0;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", tag, act, exp, $time);
    end
  endtask

  function automatic int devof(input int i);
    return (i * 37 + 11) % 256;
  endfunction

  // ---------------- behavioural reference model ----------------
  logic [NSRC-1:0] req_m = '0, en_m = '0;
  int tbl_m [NSRC];
  int e_dev = 0, e_valid = 0, e_pend = 0, e_armed = 0, e_fld = 0;

  always @(posedge clk) begin
    int w;
    if (rst) begin
      req_m = '0; en_m = '0;
      e_dev = 0; e_valid = 0; e_pend = 0; e_armed = 0; e_fld = 0;
    end else begin
      w = -1;
      for (int k = 0; k < NSRC; k++)
        if (w < 0 && req_m[k] && en_m[k]) w = k;
      if (ack_i) begin
        e_valid = 1;
        if (w >= 0) begin e_dev = tbl_m[w]; req_m[w] = 1'b0; end
        else e_dev = 0;
      end else e_valid = 0;
      if (tbl_we_i && !ack_i) tbl_m[tbl_addr_i] = int'(tbl_data_i);
      if (ctl_valid_i) begin
        case (ctl_code_i)
          2'd1: begin en_m[ctl_src_i] = 1'b1; e_armed = 1; end
          2'd2: begin en_m[ctl_src_i] = 1'b0; e_armed = 1; end
          2'd3: begin en_m[ctl_src_i] = 1'b0; req_m[ctl_src_i] = 1'b0; e_armed = 0; end
          default: e_armed = int'(ctl_armed_prev_i);
        endcase
      end
      req_m = req_m | req_set_i;
      case (fld_code_i)
        2'd1: e_fld = 1;
        2'd2: e_fld = 0;
        2'd3: e_fld = fld_old_i ? 0 : 1;
        default: e_fld = int'(fld_old_i);
      endcase
      e_pend = ((req_m & en_m) != '0) ? 1 : 0;
    end
  end

  always @(negedge clk) begin
    if (cmp_on && !rst) begin
      chk("R2 pend_o model", int'(pend_o), e_pend);
      chk("R4 ack_valid_o model", int'(ack_valid_o), e_valid);
      chk("R4 ack_dev_o model", int'(ack_dev_o), e_dev);
      chk("R7 ctl_armed_o model", int'(ctl_armed_o), e_armed);
      chk("R9 fld_new_o model", int'(fld_new_o), e_fld);
    end
  end

  // ---------------- watchdog ----------------
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d cycles", cyc, 150000);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic tick();
    @(negedge clk);
  endtask

  task automatic idle();
    req_set_i = '0; ctl_valid_i = 1'b0; ack_i = 1'b0; tbl_we_i = 1'b0;
  endtask

  task automatic ctl(input int src, input int code, input bit prev);
    ctl_valid_i = 1'b1; ctl_src_i = SRC_W'(src); ctl_code_i = 2'(code);
    ctl_armed_prev_i = prev;
    tick(); idle();
  endtask

  task automatic set_req(input int src);
    req_set_i = NSRC'(1) << src;
    tick(); idle();
  endtask

  task automatic do_ack();
    ack_i = 1'b1;
    tick(); idle();
  endtask

  initial begin
    rst = 1'b1;
    repeat (3) tick();
    // R1: reset state
    chk("R1 pend_o reset", int'(pend_o), 0);
    chk("R1 ack_valid_o reset", int'(ack_valid_o), 0);
    chk("R1 ack_dev_o reset", int'(ack_dev_o), 0);
    chk("R1 ctl_armed_o reset", int'(ctl_armed_o), 0);
    chk("R1 fld_new_o reset", int'(fld_new_o), 0);
    rst = 1'b0;
    cmp_on = 1'b1;

    // R10: load the device table
    for (int i = 0; i < NSRC; i++) begin
      tbl_we_i = 1'b1; tbl_addr_i = SRC_W'(i); tbl_data_i = DEV_W'(devof(i));
      tick();
    end
    idle();

    // R2: requests without enables stay silent
    req_set_i = (NSRC'(1) << 5) | (NSRC'(1) << 40);
    tick(); idle();
    chk("R2 request without enable", int'(pend_o), 0);

    ctl(40, 1, 1'b0);
    chk("R7 enable reports armed", int'(ctl_armed_o), 1);
    chk("R2 pend after enable", int'(pend_o), 1);
    ctl(5, 1, 1'b0);

    // R3: level 0 bit 5 beats level 1 bit 8
    do_ack();
    chk("R3 lowest index wins", int'(ack_dev_o), devof(5));
    chk("R4 valid after ack", int'(ack_valid_o), 1);
    do_ack();
    chk("R4 second winner", int'(ack_dev_o), devof(40));
    chk("R4 request cleared", int'(pend_o), 0);
    tick();
    chk("R4 valid is one cycle", int'(ack_valid_o), 0);
    do_ack();
    chk("R5 empty ack device", int'(ack_dev_o), 0);
    chk("R5 empty ack valid", int'(ack_valid_o), 1);

    // R10: write during acknowledge is dropped
    set_req(40);
    ack_i = 1'b1; tbl_we_i = 1'b1; tbl_addr_i = SRC_W'(40); tbl_data_i = 8'hC3;
    tick(); idle();
    chk("R10 ack returns old entry", int'(ack_dev_o), devof(40));
    set_req(40);
    do_ack();
    chk("R10 blocked write left entry", int'(ack_dev_o), devof(40));
    tbl_we_i = 1'b1; tbl_addr_i = SRC_W'(40); tbl_data_i = 8'hC3;
    tick(); idle();
    set_req(40);
    do_ack();
    chk("R10 normal write stored", int'(ack_dev_o), 8'hC3);

    // R6: set and acknowledge-clear of the same bit
    ctl_valid_i = 1'b1; ctl_src_i = SRC_W'(70); ctl_code_i = 2'd1;
    req_set_i = NSRC'(1) << 70;
    tick(); idle();
    ack_i = 1'b1; req_set_i = NSRC'(1) << 70;
    tick(); idle();
    chk("R6 ack result", int'(ack_dev_o), devof(70));
    chk("R6 set wins over ack clear", int'(pend_o), 1);

    // R8: disarm drops request and enable
    ctl(70, 3, 1'b1);
    chk("R8 disarm clears pending", int'(pend_o), 0);
    chk("R8 disarm reports unarmed", int'(ctl_armed_o), 0);
    set_req(70);
    chk("R8 enable dropped by disarm", int'(pend_o), 0);
    do_ack();
    chk("R8 no winner after disarm", int'(ack_dev_o), 0);

    // R7: keep copies previous state, disable reports armed
    ctl(70, 0, 1'b1);
    chk("R7 keep copies prev", int'(ctl_armed_o), 1);
    ctl(70, 3, 1'b0);
    ctl(70, 2, 1'b0);
    chk("R7 disable reports armed", int'(ctl_armed_o), 1);

    // R9: field helper truth table
    for (int c = 0; c < 4; c++) begin
      for (int o = 0; o < 2; o++) begin
        int ex;
        fld_code_i = 2'(c); fld_old_i = o[0];
        tick();
        ex = (c == 0) ? o : (c == 1) ? 1 : (c == 2) ? 0 : 1 - o;
        chk("R9 field helper", int'(fld_new_o), ex);
      end
    end

    // Random phase, checked every cycle against the model
    for (int n = 0; n < 2000; n++) begin
      req_set_i   = ($urandom % 3 == 0) ? (NSRC'(1) << ($urandom % NSRC)) : '0;
      ctl_valid_i = ($urandom % 4 == 0);
      ctl_src_i   = SRC_W'($urandom % NSRC);
      ctl_code_i  = 2'($urandom % 4);
      ctl_armed_prev_i = 1'($urandom % 2);
      ack_i       = ($urandom % 10 < 3);
      tbl_we_i    = ($urandom % 7 == 0);
      tbl_addr_i  = SRC_W'($urandom % NSRC);
      tbl_data_i  = DEV_W'($urandom % 256);
      fld_code_i  = 2'($urandom % 4);
      fld_old_i   = 1'($urandom % 2);
      tick();
    end
    idle();
    tick();

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule